// File: doc/BRIEF.md
# PHY Reset and PLL-Lock Sequencer

This block brings a serial PHY out of reset through a register-access handshake master and then waits until the PHY's receive PLL reports that it has settled. A single start pulse launches the whole sequence. First it selects the PHY clock/reset register and writes a value with the reset bit set. After that it runs a polling loop. Each pass waits a fixed number of cycles, selects the lane output status register and reads it. The loop ends when the PLL-state bit in the read value is 1.

The block drives the handshake master one command at a time. A command is a one-cycle `cmd_valid` pulse carrying an operation code and a 16-bit operand. The master answers later with `rsp_done`, an error flag and read data. The sequence finishes in one of three ways: a `done` pulse, a `fail` pulse with `timeout` set when the poll budget runs out, or a `fail` pulse without `timeout` when the master reports an error. The `polls` output keeps the number of poll passes used until the next start.

Top module: `phy_rst_lock_seq`

## Requirements
- R1: A start pulse in idle makes the block issue an address capture (op 0) with operand 0x7F3F. Once that completes, it issues a write (op 1) with operand 0x0001, which has bit 0 set.
- R2: After the write completes, the block waits POLL_DELAY cycles and then issues an address capture (op 0) of 0x2003. The `cmd_valid` pulse appears POLL_DELAY+1 cycles after the cycle in which `rsp_done` was high. The following read (op 2) is issued one cycle after that address capture completes.
- R3: A read whose bit 1 is 1 ends the sequence with a `done` pulse. All other read-data bits have no effect.
- R4: The block never makes more than POLL_LIMIT poll passes. `polls` holds the number of address-plus-read passes started in the last sequence.
- R5: If the read of pass POLL_LIMIT returns bit 1 clear, the sequence ends with `fail` and `timeout` both pulsed, and no further commands are issued.
- R6: An error response (`rsp_err`) to any command ends the sequence at once. `fail` pulses with `timeout` low, and no further commands are issued.
- R7: `done` and `fail` are one-cycle pulses and never high together. `busy` is low in the cycle they are high, and the block is back in idle.
- R8: A start pulse while `busy` is high has no effect on the command stream or the result.
- R9: After reset, `busy`, `cmd_valid`, `done`, `fail`, `timeout` and `polls` are all 0.
- R10: `cmd_valid` is high for exactly one cycle per command. No new command is issued before the previous one has received `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, used only when idle |
| busy | output | 1 | High while a sequence runs |
| cmd_valid | output | 1 | One-cycle command strobe to the handshake master |
| cmd_op | output | 2 | 0 address capture, 1 write, 2 read |
| cmd_data | output | DW | Register address or write value |
| rsp_done | input | 1 | Command completed |
| rsp_err | input | 1 | Command failed, valid with rsp_done |
| rsp_data | input | DW | Read data, valid with rsp_done |
| done | output | 1 | PLL lock seen |
| fail | output | 1 | Sequence aborted |
| timeout | output | 1 | Qualifies fail: poll budget exhausted |
| polls | output | PW | Poll passes used in the last sequence |

## Verification
The first command strobe appears one cycle after start is sampled. A read strobe follows one cycle after the address response. A poll address strobe follows POLL_DELAY+1 cycles after the response that ended the previous step. A model of the handshake master in the bench timestamps every strobe and response on the falling edge and compares these gaps exactly. The outcome pulses register on the edge that samples the final response, so the bench waits for them and samples on the following falling edge. It then checks one falling edge later that they have dropped. The sweeps cover lock on every pass from 1 to beyond the limit and an error injected at every command position.

// File: rtl/phy_rst_lock_seq.sv
module phy_rst_lock_seq #(
  parameter int POLL_DELAY = 64,
  parameter int POLL_LIMIT = 10,
  parameter int DW         = 16,
  localparam int PW        = $clog2(POLL_LIMIT + 1),
  localparam int CW        = (POLL_DELAY > 1) ? $clog2(POLL_DELAY) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [DW-1:0] cmd_data,
  input  logic          rsp_done,
  input  logic          rsp_err,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic          fail,
  output logic          timeout,
  output logic [PW-1:0] polls
);

  localparam logic [1:0]    OP_ADDR  = 2'd0;
  localparam logic [1:0]    OP_WR    = 2'd1;
  localparam logic [1:0]    OP_RD    = 2'd2;
  localparam logic [DW-1:0] REG_RST  = DW'(16'h7F3F);
  localparam logic [DW-1:0] REG_STAT = DW'(16'h2003);
  localparam logic [DW-1:0] VAL_RST  = DW'(1);

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RW, S_DLY, S_PA, S_PR} st_t;

  st_t           st;
  logic          pend;
  logic [CW-1:0] dcnt;

  wire in_cmd = (st == S_RA) || (st == S_RW) || (st == S_PA) || (st == S_PR);

  assign busy      = (st != S_IDLE);
  assign cmd_valid = in_cmd && !pend;
  assign cmd_op    = (st == S_RW) ? OP_WR : (st == S_PR) ? OP_RD : OP_ADDR;
  assign cmd_data  = (st == S_RW) ? VAL_RST : (st == S_RA) ? REG_RST : REG_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; dcnt <= '0; polls <= '0;
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RA; pend <= 1'b0; polls <= '0;
        end
        S_DLY: begin
          if (dcnt == CW'(POLL_DELAY - 1)) begin
            st <= S_PA; polls <= polls + 1'b1;
          end else dcnt <= dcnt + 1'b1;
        end
        default: begin
          if (!pend) pend <= 1'b1;
          else if (rsp_done) begin
            pend <= 1'b0;
            if (rsp_err) begin
              fail <= 1'b1; st <= S_IDLE;
            end else begin
              case (st)
                S_RA: st <= S_RW;
                S_RW: begin st <= S_DLY; dcnt <= '0; end
                S_PA: st <= S_PR;
                default: begin
                  if (rsp_data[1]) begin
                    done <= 1'b1; st <= S_IDLE;
                  end else if (polls == PW'(POLL_LIMIT)) begin
                    fail <= 1'b1; timeout <= 1'b1; st <= S_IDLE;
                  end else begin
                    st <= S_DLY; dcnt <= '0;
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assert_write_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_WR |-> cmd_data == VAL_RST);
  assert_addr_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ADDR |-> cmd_data == REG_RST || cmd_data == REG_STAT);
  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PW'(POLL_LIMIT));
  assert_timeout_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail && polls == PW'(POLL_LIMIT));
  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  assert_outcome_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

endmodule

// File: tb/phy_rst_lock_seq_tb.sv
module phy_rst_lock_seq_tb_top;
  localparam int D   = 5;
  localparam int LIM = 10;
  localparam int LAT = 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, cmd_valid, done, fail, timeout;
  logic [1:0] cmd_op;
  logic [15:0] cmd_data, rsp_data;
  logic rsp_done = 0, rsp_err = 0;
  logic [3:0] polls;

  always #5 clk = ~clk;

  phy_rst_lock_seq #(.POLL_DELAY(D), .POLL_LIMIT(LIM), .DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .done(done), .fail(fail), .timeout(timeout), .polls(polls));

  int n_tests = 0, n_fail = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // handshake master model
  int lock_at = 1, err_at = -1;
  int ncmd = 0, nreads = 0, cyc = 0, last_rsp = 0;
  bit pending = 0;
  int cnt = 0;
  bit resp_is_err = 0;

  always @(negedge clk) begin
    cyc++;
    rsp_done = 0; rsp_err = 0;
    if (pending) begin
      if (cnt == 0) begin
        rsp_done = 1; rsp_err = resp_is_err;
        rsp_data = (nreads >= lock_at) ? 16'h0002 : 16'hFFFD;
        pending = 0; last_rsp = cyc;
      end else cnt--;
    end
    if (rst_n && cmd_valid) begin
      chk(!pending, "R10", pending, 0);
      if (ncmd == 0) begin
        chk(cmd_op == 0 && cmd_data == 16'h7F3F, "R1", {cmd_op, cmd_data}, 18'h07F3F);
      end else if (ncmd == 1) begin
        chk(cmd_op == 1 && cmd_data == 16'h0001, "R1", {cmd_op, cmd_data}, 18'h10001);
      end else if (ncmd % 2 == 0) begin
        chk(cmd_op == 0 && cmd_data == 16'h2003, "R2", {cmd_op, cmd_data}, 18'h02003);
        chk(cyc - last_rsp == D + 1, "R2", cyc - last_rsp, D + 1);
      end else begin
        chk(cmd_op == 2, "R2", cmd_op, 2);
        chk(cyc - last_rsp == 1, "R2", cyc - last_rsp, 1);
        nreads++;
      end
      resp_is_err = (ncmd == err_at);
      ncmd++;
      pending = 1; cnt = LAT;
    end
  end

  task automatic run(int la, int ea, int extra_start, int exp_res, int exp_polls, int exp_cmds);
    int k;
    int res;
    lock_at = la; err_at = ea; ncmd = 0; nreads = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    k = 0;
    while (!(done || fail) && k < 5000) begin
      start = (k == extra_start);
      @(negedge clk); k++;
    end
    start = 0;
    if (k >= 5000) begin
      chk(0, "watchdog", k, 0);
      return;
    end
    res = done ? 0 : (timeout ? 1 : 2);
    chk(res == exp_res, exp_res == 0 ? "R3" : (exp_res == 1 ? "R5" : "R6"), res, exp_res);
    chk(!busy, "R7", busy, 0);
    chk(int'(polls) == exp_polls, "R4", polls, exp_polls);
    @(negedge clk);
    chk(!done && !fail && !timeout, "R7", {done, fail, timeout}, 0);
    repeat (20) @(negedge clk);
    chk(ncmd == exp_cmds, extra_start >= 0 ? "R8" : "R6", ncmd, exp_cmds);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !done && !fail && !timeout && polls == 0, "R9",
        {busy, cmd_valid, done, fail, timeout}, 0);
    rst_n = 1;
    @(negedge clk);
    // lock on each pass, and beyond the limit
    for (int la = 1; la <= LIM + 2; la++) begin
      if (la <= LIM) run(la, -1, -1, 0, la, 2 + 2 * la);
      else run(la, -1, -1, 1, LIM, 2 + 2 * LIM);
    end
    // error at every command position
    for (int e = 0; e < 8; e++)
      run(3, e, -1, 2, (e < 2) ? 0 : (e - 2) / 2 + 1, e + 1);
    // start while busy ignored
    run(4, -1, 12, 0, 4, 10);
    run(4, -1, 3, 0, 4, 10);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule